// File: doc/BRIEF.md
# Display PLL Reprogramming Sequencer

This block steps a display PLL safely from one set of dividers to another. The dividers are worked out elsewhere. It latches the already-encoded M, N and P1 fields and the target dot clock when `start` is pulsed. It then issues a fixed series of register transactions on a simple bus: turn the PLL off, load the divider register, and turn the PLL back on. After that it counts out the lock time and pulses `done`.

Two port styles are handled, and each has its own control-word layout. The panel style needs no readback. It uses a short disable word, places M in a byte-shifted divider word, and uses a single enable word. The serial style first reads the two low mode bits of the control register so that it can keep them. While the PLL is off, it parks P at a safe value of 2. It picks a port multiplier of 1, 2 or 4 from the dot clock and writes that multiplier's code into the enable word. It writes the enable word twice back to back. A divider search alongside the block uses the multiplied target clock that the block presents, and the block divides the achieved clock back down for reporting.

Top module: `pllseq_top`

## Requirements
- R1: While reset is held and in the cycle after it is released, `busy`, `done`, `bus_wr`, `bus_rd`, `bus_addr` and `bus_wdata` are all zero. No strobe is ever raised while `busy` is low.
- R2: Panel style (`serial_port`=0) writes three words in this order. First, the control address gets a word with only bit 28 set. Second, the divider address gets M at bits [15:8]. Third, the control address gets bits 31, 28 and 27 set with P1 in the P field at bits [P_SHIFT+7:P_SHIFT]. No read is issued in this style.
- R3: Serial style (`serial_port`=1) first reads the control address and waits for `rd_valid`. It then writes a disable word to the control address with bit 28 set, the value 2 in the P field, and bits [1:0] equal to the two bits read back.
- R4: The serial-style divider write puts N at bits [23:16] and M at bits [7:0], with all other bits zero.
- R5: The serial-style enable word sets bits 31, 30 and 28, P1 in the P field, the preserved bits [1:0], and the multiplier code in bits [5:4]. This word is written to the control address in two consecutive accepted writes.
- R6: Serial-style multiplier bands: above 100000 kHz the multiplier is 1 (code 0), above 50000 kHz it is 2 (code 1), and otherwise it is 4 (code 3). Panel style always uses 1. One cycle after the inputs are set, `scaled_khz` equals `dclk_khz` times the multiplier and `achieved_port_khz` equals `achieved_khz` divided by it.
- R7: In serial style with `ext_src`=1, `src_bits` is ORed into the enable word. With `ext_src`=0 it has no effect.
- R8: A write strobe keeps its address and data unchanged until it is accepted by `wr_ready`, and the sequence only moves on after acceptance. A read strobe is held until `rd_valid`.
- R9: After the last enable write is accepted, exactly CLK_KHZ*SETTLE_US/1000 cycles pass with `busy` high and no strobe. `done` then pulses for one cycle with `busy` low.
- R10: Inputs are captured on the accepted `start`. A `start` or any field change while `busy` is high has no effect on the transactions issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a reprogramming sequence (taken when idle) |
| serial_port | input | 1 | 0 = panel style, 1 = serial style |
| m_code | input | M_W | Encoded M divider field |
| n_code | input | N_W | Encoded N divider field (serial style) |
| p1_code | input | P_W | Encoded P1 field |
| dclk_khz | input | KW | Target dot clock in kHz |
| achieved_khz | input | KW | Achieved clock from the divider search, port-scaled |
| ext_src | input | 1 | External clock source selected |
| src_bits | input | DW | Clock-source bits ORed into the enable word |
| rd_low | input | 2 | Low two bits of the control register on readback |
| rd_valid | input | 1 | Readback data valid |
| wr_ready | input | 1 | Bus accepts the current write |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the settle time ends |
| scaled_khz | output | KW | Dot clock times the port multiplier |
| achieved_port_khz | output | KW | Achieved clock divided by the port multiplier |

## Verification
The assertions assume a bus that eventually raises `wr_ready` and `rd_valid`. They also assume that `rd_low` is meaningful only while `rd_valid` is high, and that the P field parameter does not overlap bits [5:0] or [31:27]. The stimulus applies back-pressure on a repeating pattern, so every write sees both stalled and accepted cycles. It drives `rd_low` only through the readback handshake. It keeps P_SHIFT at 16 and uses a short settle time, so several full sequences fit into one run.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_DIS    = 3'd2,
    ST_DIV    = 3'd3,
    ST_EN1    = 3'd4,
    ST_EN2    = 3'd5,
    ST_SETTLE = 3'd6
  } step_e;

  localparam int KEEP_W   = 2;
  localparam int MCODE_LO = 4;
  localparam int SAFE_P   = 2;

  function automatic logic is_write(step_e s);
    return (s == ST_DIS) || (s == ST_DIV) || (s == ST_EN1) || (s == ST_EN2);
  endfunction

endpackage

// File: rtl/pllseq_band.sv
module pllseq_band #(
  parameter int KW   = 32,
  parameter int HI   = 100000,
  parameter int MID  = 50000
) (
  input  logic [KW-1:0] khz,
  input  logic          serial,
  output logic [1:0]    shift,
  output logic [1:0]    code
);
  always_comb begin
    if (!serial || (khz > KW'(HI))) begin
      shift = 2'd0;
      code  = 2'd0;
    end else if (khz > KW'(MID)) begin
      shift = 2'd1;
      code  = 2'd1;
    end else begin
      shift = 2'd2;
      code  = 2'd3;
    end
  end
endmodule

// File: rtl/pllseq_wordgen.sv
module pllseq_wordgen
  import pllseq_pkg::*;
#(
  parameter int          AW        = 12,
  parameter int          DW        = 32,
  parameter int          M_W       = 8,
  parameter int          N_W       = 8,
  parameter int          P_W       = 8,
  parameter int          P_SHIFT   = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 12'h014,
  parameter logic [AW-1:0] DIV_ADDR  = 12'h040
) (
  input  step_e              step,
  input  logic               serial,
  input  logic [M_W-1:0]     m,
  input  logic [N_W-1:0]     n,
  input  logic [P_W-1:0]     p1,
  input  logic [KEEP_W-1:0]  keep,
  input  logic [1:0]         mcode,
  input  logic               ext,
  input  logic [DW-1:0]      src,
  output logic [AW-1:0]      addr,
  output logic [DW-1:0]      data
);
  always_comb begin
    addr = CTRL_ADDR;
    data = '0;
    case (step)
      ST_DIS: begin
        data[28] = 1'b1;
        if (serial) begin
          data[P_SHIFT +: P_W] = P_W'(SAFE_P);
          data[KEEP_W-1:0]     = keep;
        end
      end
      ST_DIV: begin
        addr = DIV_ADDR;
        if (serial) begin
          data[16 +: N_W] = n;
          data[0 +: M_W]  = m;
        end else begin
          data[8 +: M_W]  = m;
        end
      end
      ST_EN1, ST_EN2: begin
        data[31] = 1'b1;
        data[28] = 1'b1;
        data[P_SHIFT +: P_W] = p1;
        if (serial) begin
          data[30]                = 1'b1;
          data[KEEP_W-1:0]        = keep;
          data[MCODE_LO +: 2]     = mcode;
          if (ext) data = data | src;
        end else begin
          data[27] = 1'b1;
        end
      end
      default: begin
        addr = CTRL_ADDR;
        data = '0;
      end
    endcase
  end
endmodule

// File: rtl/pllseq_settle.sv
module pllseq_settle #(
  parameter int CYC = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign last = run && (cnt == CW'(CYC - 1));
endmodule

// File: rtl/pllseq_top.sv
module pllseq_top
  import pllseq_pkg::*;
#(
  parameter int            AW        = 12,
  parameter int            DW        = 32,
  parameter int            KW        = 32,
  parameter int            M_W       = 8,
  parameter int            N_W       = 8,
  parameter int            P_W       = 8,
  parameter int            P_SHIFT   = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 12'h014,
  parameter logic [AW-1:0] DIV_ADDR  = 12'h040,
  parameter int            CLK_KHZ   = 250000,
  parameter int            SETTLE_US = 150
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              serial_port,
  input  logic [M_W-1:0]    m_code,
  input  logic [N_W-1:0]    n_code,
  input  logic [P_W-1:0]    p1_code,
  input  logic [KW-1:0]     dclk_khz,
  input  logic [KW-1:0]     achieved_khz,
  input  logic              ext_src,
  input  logic [DW-1:0]     src_bits,
  input  logic [1:0]        rd_low,
  input  logic              rd_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic              busy,
  output logic              done,
  output logic [KW-1:0]     scaled_khz,
  output logic [KW-1:0]     achieved_port_khz
);
  localparam int CYC_RAW = (CLK_KHZ / 1000) * SETTLE_US;
  localparam int CYC     = (CYC_RAW < 1) ? 1 : CYC_RAW;

  step_e              state, nxt;
  logic               serial_q, ext_q;
  logic [M_W-1:0]     m_q;
  logic [N_W-1:0]     n_q;
  logic [P_W-1:0]     p1_q;
  logic [1:0]         code_q;
  logic [KEEP_W-1:0]  keep_q;
  logic [DW-1:0]      src_q;

  logic [1:0]         band_shift, band_code;
  logic               settle_last;

  logic               f_serial, f_ext;
  logic [M_W-1:0]     f_m;
  logic [N_W-1:0]     f_n;
  logic [P_W-1:0]     f_p1;
  logic [1:0]         f_code;
  logic [KEEP_W-1:0]  f_keep;
  logic [DW-1:0]      f_src;
  logic [AW-1:0]      w_addr;
  logic [DW-1:0]      w_data;

  pllseq_band #(.KW(KW)) band_i (
    .khz    (dclk_khz),
    .serial (serial_port),
    .shift  (band_shift),
    .code   (band_code)
  );

  pllseq_settle #(.CYC(CYC)) settle_i (
    .clk  (clk),
    .rst  (rst),
    .run  (state == ST_SETTLE),
    .last (settle_last)
  );

  // next step
  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (start) nxt = serial_port ? ST_READ : ST_DIS;
      ST_READ:   if (rd_valid) nxt = ST_DIS;
      ST_DIS:    if (wr_ready) nxt = ST_DIV;
      ST_DIV:    if (wr_ready) nxt = ST_EN1;
      ST_EN1:    if (wr_ready) nxt = serial_q ? ST_EN2 : ST_SETTLE;
      ST_EN2:    if (wr_ready) nxt = ST_SETTLE;
      ST_SETTLE: if (settle_last) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  // fields seen by the word generator: live on the start edge, latched after
  always_comb begin
    if (state == ST_IDLE) begin
      f_serial = serial_port;
      f_ext    = ext_src;
      f_m      = m_code;
      f_n      = n_code;
      f_p1     = p1_code;
      f_code   = band_code;
      f_src    = src_bits;
    end else begin
      f_serial = serial_q;
      f_ext    = ext_q;
      f_m      = m_q;
      f_n      = n_q;
      f_p1     = p1_q;
      f_code   = code_q;
      f_src    = src_q;
    end
    f_keep = (state == ST_READ) ? rd_low : keep_q;
  end

  pllseq_wordgen #(
    .AW(AW), .DW(DW), .M_W(M_W), .N_W(N_W), .P_W(P_W),
    .P_SHIFT(P_SHIFT), .CTRL_ADDR(CTRL_ADDR), .DIV_ADDR(DIV_ADDR)
  ) wordgen_i (
    .step   (nxt),
    .serial (f_serial),
    .m      (f_m),
    .n      (f_n),
    .p1     (f_p1),
    .keep   (f_keep),
    .mcode  (f_code),
    .ext    (f_ext),
    .src    (f_src),
    .addr   (w_addr),
    .data   (w_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      serial_q <= 1'b0;
      ext_q    <= 1'b0;
      m_q      <= '0;
      n_q      <= '0;
      p1_q     <= '0;
      code_q   <= '0;
      keep_q   <= '0;
      src_q    <= '0;
      bus_addr <= '0;
      bus_wdata<= '0;
      bus_wr   <= 1'b0;
      bus_rd   <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && start) begin
        serial_q <= serial_port;
        ext_q    <= ext_src;
        m_q      <= m_code;
        n_q      <= n_code;
        p1_q     <= p1_code;
        code_q   <= band_code;
        src_q    <= src_bits;
      end
      if (state == ST_READ && rd_valid) keep_q <= rd_low;
      bus_wr <= is_write(nxt);
      bus_rd <= (nxt == ST_READ);
      busy   <= (nxt != ST_IDLE);
      done   <= (state == ST_SETTLE) && settle_last;
      if (is_write(nxt) || nxt == ST_READ) begin
        bus_addr  <= w_addr;
        bus_wdata <= (nxt == ST_READ) ? '0 : w_data;
      end else begin
        bus_addr  <= '0;
        bus_wdata <= '0;
      end
    end
  end

  // port-multiplier scaling of the clocks exchanged with the divider search
  always_ff @(posedge clk) begin
    if (rst) begin
      scaled_khz        <= '0;
      achieved_port_khz <= '0;
    end else begin
      scaled_khz        <= dclk_khz << band_shift;
      achieved_port_khz <= achieved_khz >> band_shift;
    end
  end

endmodule

// File: rtl/pllseq_chk.sv
module pllseq_chk #(
  parameter int            AW        = 12,
  parameter int            DW        = 32,
  parameter logic [AW-1:0] CTRL_ADDR = 12'h014
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          busy,
  input logic          done
);
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!bus_wr && !bus_rd));

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_wr, bus_rd}));

  assert_write_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !wr_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

  assert_read_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !rd_valid) |=> bus_rd);

  assert_disable_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == CTRL_ADDR && !bus_wdata[31]) |-> bus_wdata[28]);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind pllseq_top pllseq_chk #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .busy      (busy),
  .done      (done)
);

// File: tb/pllseq_tb.sv
module pllseq_top_tb_top;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int KW = 32;
  localparam logic [AW-1:0] CTRL = 12'h014;
  localparam logic [AW-1:0] DIVA = 12'h040;
  localparam int SETTLE_US = 2;
  localparam int WAIT_CYC  = 250 * SETTLE_US;
  localparam int IW = AW + DW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, serial_port = 1'b0, ext_src = 1'b0;
  logic [7:0] m_code = '0, n_code = '0, p1_code = '0;
  logic [KW-1:0] dclk_khz = '0, achieved_khz = '0;
  logic [DW-1:0] src_bits = '0;
  logic [1:0] rd_low = '0;
  logic rd_valid = 1'b0, wr_ready = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_wr, bus_rd, busy, done;
  logic [KW-1:0] scaled_khz, achieved_port_khz;

  int n_checks = 0, n_fail = 0, done_cnt = 0, settle_n = 0;
  logic [IW-1:0] exp_q[$];
  logic [1:0] rd_feed = 2'b00;

  always #2 clk = ~clk;

  pllseq_top #(.AW(AW), .DW(DW), .KW(KW), .CTRL_ADDR(CTRL), .DIV_ADDR(DIVA),
               .CLK_KHZ(250000), .SETTLE_US(SETTLE_US)) dut_i (
    .clk(clk), .rst(rst), .start(start), .serial_port(serial_port),
    .m_code(m_code), .n_code(n_code), .p1_code(p1_code),
    .dclk_khz(dclk_khz), .achieved_khz(achieved_khz),
    .ext_src(ext_src), .src_bits(src_bits), .rd_low(rd_low),
    .rd_valid(rd_valid), .wr_ready(wr_ready),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .busy(busy), .done(done),
    .scaled_khz(scaled_khz), .achieved_port_khz(achieved_port_khz));

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mult_of(input logic [KW-1:0] k);
    if (k > 100000) return 1;
    if (k > 50000)  return 2;
    return 4;
  endfunction

  function automatic logic [1:0] code_of(input int mu);
    return (mu == 1) ? 2'd0 : (mu == 2) ? 2'd1 : 2'd3;
  endfunction

  // back-pressure pattern
  int ph = 0;
  always @(posedge clk) begin
    #1;
    ph++;
    wr_ready <= (ph % 3) != 1;
    rd_valid <= (ph % 4) == 3;
    rd_low   <= ((ph % 4) == 3) ? rd_feed : ~rd_feed;
  end

  // monitor / scoreboard
  logic          prev_stall = 1'b0;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_data;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        check(bus_wr && bus_addr == prev_addr && bus_wdata == prev_data,
              "R8 held write", {bus_addr, bus_wdata}, {prev_addr, prev_data});
      prev_stall = bus_wr && !wr_ready;
      prev_addr  = bus_addr;
      prev_data  = bus_wdata;
      if (bus_rd && rd_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected read", 64'(bus_addr), 0);
        else begin
          logic [IW-1:0] e;
          e = exp_q.pop_front();
          check(e[IW-1] == 1'b1 && bus_addr == e[DW +: AW], "R3 readback",
                {1'b1, bus_addr}, {e[IW-1], e[DW +: AW]});
        end
      end
      if (bus_wr && wr_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected write", {bus_addr, bus_wdata}, 0);
        else begin
          logic [IW-1:0] e;
          e = exp_q.pop_front();
          check(e[IW-1] == 1'b0 && bus_addr == e[DW +: AW] && bus_wdata == e[DW-1:0],
                "R2/R3/R4/R5/R7 write word", {bus_addr, bus_wdata}, {e[DW +: AW], e[DW-1:0]});
        end
      end
      if (busy && !bus_wr && !bus_rd) settle_n++;
      if (done) begin
        check(settle_n == WAIT_CYC, "R9 settle length", 64'(settle_n), 64'(WAIT_CYC));
        check(!busy, "R9 done with busy low", 64'(busy), 0);
        check(exp_q.size() == 0, "R10 sequence complete", 64'(exp_q.size()), 0);
        settle_n = 0;
        done_cnt++;
      end
    end
  end

  task automatic push(input logic rd, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_q.push_back({rd, a, d});
  endtask

  task automatic run_seq(input logic ser, input logic [7:0] m, input logic [7:0] n,
                         input logic [7:0] p1, input logic [KW-1:0] dk, input logic ex,
                         input logic [DW-1:0] src, input logic [1:0] keep,
                         input logic poke);
    int target;
    logic [DW-1:0] w;
    target = done_cnt + 1;
    rd_feed = keep;
    if (!ser) begin
      push(0, CTRL, 32'h1000_0000);                      // R2 disable
      push(0, DIVA, {16'h0, m, 8'h00});                  // R2 divider
      push(0, CTRL, 32'h9800_0000 | ({24'h0, p1} << 16)); // R2 enable
    end else begin
      push(1, CTRL, '0);                                  // R3 read
      push(0, CTRL, 32'h1002_0000 | {30'h0, keep});       // R3 disable, P=2
      push(0, DIVA, {8'h0, n, 8'h0, m});                  // R4
      w = 32'hD000_0000 | ({24'h0, p1} << 16) | {30'h0, keep}
          | ({30'h0, code_of(mult_of(dk))} << 4);         // R5
      if (ex) w = w | src;                                // R7
      push(0, CTRL, w);
      push(0, CTRL, w);
    end
    @(posedge clk); #1;
    serial_port = ser; m_code = m; n_code = n; p1_code = p1;
    dclk_khz = dk; ext_src = ex; src_bits = src; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin // R10: changes and a second start while busy
      repeat (3) @(posedge clk);
      #1;
      m_code = ~m; n_code = ~n; p1_code = ~p1; ext_src = ~ex;
      serial_port = ~ser; dclk_khz = 32'd20000; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    wait (done_cnt == target);
    repeat (3) @(posedge clk);
  endtask

  task automatic scale_chk(input logic [KW-1:0] dk, input logic [KW-1:0] ach);
    int mu;
    mu = mult_of(dk);
    @(posedge clk); #1;
    serial_port = 1'b1; dclk_khz = dk; achieved_khz = ach;
    @(posedge clk); @(negedge clk);
    check(scaled_khz == dk * mu, "R6 scaled", 64'(scaled_khz), 64'(dk * mu));
    check(achieved_port_khz == ach / mu, "R6 achieved", 64'(achieved_port_khz), 64'(ach / mu));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!busy && !done && !bus_wr && !bus_rd && bus_addr == 0 && bus_wdata == 0,
          "R1 reset state", {busy, done, bus_wr, bus_rd}, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !bus_wr && !bus_rd, "R1 after release",
          {busy, done, bus_wr, bus_rd}, 0);

    run_seq(1'b0, 8'h2D, 8'h00, 8'h04, 32'd65000, 1'b0, '0, 2'b00, 1'b0);         // R2
    run_seq(1'b1, 8'h5A, 8'h10, 8'h02, 32'd120000, 1'b0, 32'h0000_2000, 2'b10, 1'b0); // R3 R5 R7 off
    run_seq(1'b1, 8'h33, 8'h04, 8'h08, 32'd75000, 1'b1, 32'h0000_2000, 2'b01, 1'b0);  // R7
    run_seq(1'b1, 8'h71, 8'h20, 8'h01, 32'd30000, 1'b0, '0, 2'b11, 1'b1);             // R10
    run_seq(1'b0, 8'h0B, 8'h00, 8'h02, 32'd150000, 1'b1, 32'h0000_0F00, 2'b00, 1'b1); // R10 panel

    scale_chk(32'd100001, 32'd100001);  // R6 band 1
    scale_chk(32'd100000, 32'd200000);  // R6 boundary -> 2
    scale_chk(32'd50001, 32'd100002);   // R6 band 2
    scale_chk(32'd50000, 32'd200000);   // R6 boundary -> 4
    @(posedge clk); #1;
    serial_port = 1'b0; dclk_khz = 32'd30000; achieved_khz = 32'd30000;
    @(posedge clk); @(negedge clk);
    check(scaled_khz == 32'd30000, "R6 panel mult 1", 64'(scaled_khz), 64'd30000);

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule